// File: doc/BRIEF.md
# Two-Wavefront Systolic L·U·R Matrix Engine

This block evaluates the product V = L·U·R on a square grid of synchronous nodes. L and R are small square coefficient matrices, typically the two factors of a Kronecker-product split of a state-space filter matrix. U is built from an operand vector: consecutive segments of length DIM become the columns of U. V is read back in the same column-major way, so it forms the updated state and output vector. The whole product takes O(2·DIM) steps rather than the O(DIM²) steps of a plain matrix-vector array.

Each node holds one entry of L. In the first wavefront, rows of U stream down the columns of the grid. Every node multiplies the passing operand by its L entry, adds the partial sum arriving from its left neighbour, and hands the sum to its right. The right edge of each row then produces one row of L·U. Directly behind the U operands, the rows of R stream down the same columns. A phase tag travels with every operand word, so each node switches mode when the first R word reaches it. In the second mode a node forwards everything unchanged and accumulates one entry of V from the L·U values, which are wrapped back into the row's left end, and the R values passing by.

Software writes L and R through a small indexed write port, pushes the DIM columns of U as beats, pulses `start`, waits for the single-cycle `done`, and then reads any V entry through an index-addressed output.

Top module: `lur_cyl_array`

## Requirements
- R1: After reset, `done` is 0 and `v_out` reads 0 for every `rd_row`/`rd_col` index.
- R2: When `cfg_we` is 1 with `cfg_sel`=0, `cfg_data` is written into L[`cfg_row`][`cfg_col`]; with `cfg_sel`=1 it is written into R. Each `u_valid` beat stores `u_col` as the next column of U, starting at column 0 after reset and wrapping after DIM beats. Element r of a beat sits in bits [16r+15:16r]. Column c therefore holds vector entries c·DIM to c·DIM+DIM−1.
- R3: After a run, reading index (i,j) gives the entry V[i][j] = Σk (Σm L[i][m]·U[m][k])·R[k][j]. When no saturation occurs, this equals entry j·DIM+i of the Kronecker matrix (Rᵀ⊗L) applied to the operand vector.
- R4: Each intermediate L·U entry is clamped to the signed 20-bit range before it enters the second wavefront.
- R5: The accumulation of V runs in order of k and clamps to the signed 36-bit range at every step. `v_out` clamps the result to [−32768, 32767].
- R6: `done` is high for exactly one cycle, 4·DIM−2 rising edges after the edge that samples `start` (6 edges for DIM=2).
- R7: A `start` pulse that arrives while a run is in progress is ignored: it produces no second `done` and does not shift the timing of the first.
- R8: Every run computes V from zero. A node clears its accumulator when it receives its first R word, so repeated runs do not add up.
- R9: After `done`, V is held until the next run. Writes to L, R or U that are not followed by `start` leave `v_out` unchanged.
- R10: Each node enters accumulate mode exactly one cycle after its last L·U step. At any cycle at most one grid column receives the first R word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Coefficient target: 0 = L, 1 = R |
| cfg_row | input | 1 | Coefficient row index |
| cfg_col | input | 1 | Coefficient column index |
| cfg_data | input | 16 | Signed coefficient value |
| u_valid | input | 1 | Operand column beat strobe |
| u_col | input | 32 | One column of U, element r at bits [16r+15:16r] |
| start | input | 1 | Single-cycle launch pulse |
| done | output | 1 | One-cycle completion pulse |
| rd_row | input | 1 | V read row index |
| rd_col | input | 1 | V read column index |
| v_out | output | 16 | Saturated signed V[rd_row][rd_col] |

## Verification
The hardest case to reach from the ports is the clamp on the intermediate L·U values. Once V is clamped to 16 bits at the output, a wrong intermediate width is usually hidden by the output clamp. The bench therefore builds one case with two large L·U entries of the same sign: one is just above the 20-bit limit and one is just inside it, and an R column of the form (1, −1) subtracts them. The small result then appears only if the intermediate clamp works. A second case drives the 36-bit accumulator past its positive limit, where wrap-around would appear as a negative full-scale output. A start pulse issued in the middle of a run, checked against a cycle-accurate model of `done`, covers the ignore rule.

// File: rtl/lur_pkg.sv
package lur_pkg;

    // Grid dimension (p = q) and datapath widths
    parameter int DIM    = 2;
    parameter int DW     = 16;
    parameter int ACC_W  = 36;
    parameter int FB_W   = ACC_W - DW;                 // width of wrapped L*U values
    parameter int TW     = 2 * DW + $clog2(DIM) + 1;   // transversal partial-sum width
    parameter int IW     = (DIM > 1) ? $clog2(DIM) : 1;
    parameter int LAST_T = 4 * DIM - 3;                // last step of a run
    parameter int TCW    = $clog2(LAST_T + 1);

    // Phase tag carried with every longitudinal word
    typedef enum logic [1:0] {
        TAG_IDLE    = 2'd0,
        TAG_LU      = 2'd1,
        TAG_V_FIRST = 2'd2,
        TAG_V       = 2'd3
    } tag_e;

    typedef struct packed {
        tag_e                  tag;
        logic signed [DW-1:0]  val;
    } lon_t;

    typedef enum logic {
        SEL_L = 1'b0,
        SEL_R = 1'b1
    } cfg_sel_e;

    // Clamp a transversal partial sum into the feedback width
    function automatic logic signed [FB_W-1:0] sat_fb(input logic signed [TW-1:0] x);
        logic signed [TW-1:0] hi;
        logic signed [TW-1:0] lo;
        hi = TW'((longint'(1) <<< (FB_W - 1)) - 1);
        lo = -hi - TW'(1);
        if (x > hi)      return hi[FB_W-1:0];
        else if (x < lo) return lo[FB_W-1:0];
        else             return x[FB_W-1:0];
    endfunction

    // Saturating accumulate in ACC_W bits
    function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [ACC_W-1:0] a,
                                                        input logic signed [ACC_W-1:0] b);
        logic signed [ACC_W:0] s;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        s  = (ACC_W+1)'(a) + (ACC_W+1)'(b);
        hi = (ACC_W+1)'((longint'(1) <<< (ACC_W - 1)) - 1);
        lo = -hi - (ACC_W+1)'(1);
        if (s > hi)      return hi[ACC_W-1:0];
        else if (s < lo) return lo[ACC_W-1:0];
        else             return s[ACC_W-1:0];
    endfunction

    // Clamp an accumulator into the output width
    function automatic logic signed [DW-1:0] sat_out(input logic signed [ACC_W-1:0] x);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = ACC_W'((longint'(1) <<< (DW - 1)) - 1);
        lo = -hi - ACC_W'(1);
        if (x > hi)      return hi[DW-1:0];
        else if (x < lo) return lo[DW-1:0];
        else             return x[DW-1:0];
    endfunction

endpackage

// File: rtl/lur_seq.sv
module lur_seq
    import lur_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           run,
    output logic [TCW-1:0] t,
    output logic           done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            t    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (start) begin
                    run <= 1'b1;
                    t   <= '0;
                end
            end else if (t == TCW'(LAST_T)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end else begin
                t <= t + TCW'(1);
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $fell(run)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (run && start && t != TCW'(LAST_T)) |=> (run && t == $past(t) + TCW'(1))); // R7

endmodule

// File: rtl/lur_feeder.sv
module lur_feeder
    import lur_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 u_valid,
    input  logic [DIM*DW-1:0]    u_col,
    input  logic                 r_we,
    input  logic [IW-1:0]        r_row,
    input  logic [IW-1:0]        r_col,
    input  logic signed [DW-1:0] r_data,
    input  logic                 run,
    input  logic [TCW-1:0]       t,
    output lon_t                 col_in [DIM]
);

    logic signed [DW-1:0] u_mem [DIM][DIM];   // [row][col]
    logic signed [DW-1:0] r_mem [DIM][DIM];   // [row][col]
    logic [IW-1:0]        uidx;
    logic [DIM-1:0]       first_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            uidx <= '0;
            for (int a = 0; a < DIM; a++) begin
                for (int b = 0; b < DIM; b++) begin
                    u_mem[a][b] <= '0;
                    r_mem[a][b] <= '0;
                end
            end
        end else begin
            if (u_valid) begin
                for (int r = 0; r < DIM; r++) begin
                    u_mem[r][uidx] <= u_col[r*DW +: DW];
                end
                uidx <= (uidx == IW'(DIM - 1)) ? '0 : uidx + IW'(1);
            end
            if (r_we) begin
                r_mem[r_row][r_col] <= r_data;
            end
        end
    end

    // Column c sees its stream skewed by c steps: DIM U words, then DIM R words
    always_comb begin
        for (int c = 0; c < DIM; c++) begin
            col_in[c] = '{tag: TAG_IDLE, val: '0};
            if (run) begin
                if (int'(t) >= c && int'(t) < c + DIM) begin
                    col_in[c] = '{tag: TAG_LU, val: u_mem[c][IW'(int'(t) - c)]};
                end else if (int'(t) == c + DIM) begin
                    col_in[c] = '{tag: TAG_V_FIRST, val: r_mem[0][c]};
                end else if (int'(t) > c + DIM && int'(t) < c + 2 * DIM) begin
                    col_in[c] = '{tag: TAG_V, val: r_mem[IW'(int'(t) - c - DIM)][c]};
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < DIM; c++) begin
            first_v[c] = (col_in[c].tag == TAG_V_FIRST);
        end
    end

    AST_ONE_WAVE_ENTRY: assert property (@(posedge clk) disable iff (rst) $onehot0(first_v)); // R10

endmodule

// File: rtl/lur_node.sv
module lur_node
    import lur_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    l_we,
    input  logic signed [DW-1:0]    l_data,
    input  lon_t                    lon_in,
    input  logic signed [TW-1:0]    tr_in,
    output lon_t                    lon_q,
    output logic signed [TW-1:0]    tr_q,
    output logic signed [ACC_W-1:0] acc_q
);

    logic signed [DW-1:0]    l_q;
    logic signed [TW-1:0]    lu_prod;
    logic signed [FB_W-1:0]  fb;
    logic signed [ACC_W-1:0] v_prod;

    always_comb begin
        lu_prod = TW'(l_q) * TW'($signed(lon_in.val));
        fb      = sat_fb(tr_in);
        v_prod  = ACC_W'(fb) * ACC_W'($signed(lon_in.val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q   <= '0;
            lon_q <= '{tag: TAG_IDLE, val: '0};
            tr_q  <= '0;
            acc_q <= '0;
        end else begin
            if (l_we) begin
                l_q <= l_data;
            end
            lon_q <= lon_in;
            unique case (lon_in.tag)
                TAG_LU: begin
                    tr_q <= tr_in + lu_prod;
                end
                TAG_V_FIRST: begin
                    tr_q  <= tr_in;
                    acc_q <= sat_acc('0, v_prod);
                end
                TAG_V: begin
                    tr_q  <= tr_in;
                    acc_q <= sat_acc(acc_q, v_prod);
                end
                default: begin
                    tr_q <= tr_in;
                end
            endcase
        end
    end

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst) (lon_in.tag == TAG_V_FIRST) |-> ($past(lon_in.tag) == TAG_LU)); // R10
    AST_ACC_HELD: assert property (@(posedge clk) disable iff (rst) (lon_in.tag == TAG_IDLE || lon_in.tag == TAG_LU) |=> $stable(acc_q)); // R9
    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst) (lon_in.tag == TAG_V_FIRST && lon_in.val == '0) |=> (acc_q == '0)); // R8

endmodule

// File: rtl/lur_cyl_array.sv
module lur_cyl_array
    import lur_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [IW-1:0]        cfg_row,
    input  logic [IW-1:0]        cfg_col,
    input  logic signed [DW-1:0] cfg_data,
    input  logic                 u_valid,
    input  logic [DIM*DW-1:0]    u_col,
    input  logic                 start,
    output logic                 done,
    input  logic [IW-1:0]        rd_row,
    input  logic [IW-1:0]        rd_col,
    output logic signed [DW-1:0] v_out
);

    logic                    run;
    logic [TCW-1:0]          t;
    logic                    r_we;
    lon_t                    col_in  [DIM];
    lon_t                    lon_in_w [DIM][DIM];
    lon_t                    lon_q   [DIM][DIM];
    logic signed [TW-1:0]    tr_in_w [DIM][DIM];
    logic signed [TW-1:0]    tr_q    [DIM][DIM];
    logic signed [ACC_W-1:0] acc_q   [DIM][DIM];
    logic                    l_we_w  [DIM][DIM];

    assign r_we = cfg_we && (cfg_sel == SEL_R);

    lur_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (run),
        .t     (t),
        .done  (done)
    );

    lur_feeder u_feed (
        .clk     (clk),
        .rst     (rst),
        .u_valid (u_valid),
        .u_col   (u_col),
        .r_we    (r_we),
        .r_row   (cfg_row),
        .r_col   (cfg_col),
        .r_data  (cfg_data),
        .run     (run),
        .t       (t),
        .col_in  (col_in)
    );

    for (genvar gi = 0; gi < DIM; gi++) begin : g_row
        for (genvar gj = 0; gj < DIM; gj++) begin : g_col
            // Longitudinal path: from the feeder on the top row, from the node above otherwise
            if (gi == 0) begin : g_top
                assign lon_in_w[gi][gj] = col_in[gj];
            end else begin : g_below
                assign lon_in_w[gi][gj] = lon_q[gi-1][gj];
            end
            // Transversal path: the left edge starts at zero in the first wavefront and
            // takes the wrapped row output in the second
            if (gj == 0) begin : g_left
                assign tr_in_w[gi][gj] = (lon_in_w[gi][gj].tag == TAG_LU) ? '0 : tr_q[gi][DIM-1];
            end else begin : g_inner
                assign tr_in_w[gi][gj] = tr_q[gi][gj-1];
            end

            assign l_we_w[gi][gj] = cfg_we && (cfg_sel == SEL_L)
                                    && (cfg_row == IW'(gi)) && (cfg_col == IW'(gj));

            lur_node u_node (
                .clk    (clk),
                .rst    (rst),
                .l_we   (l_we_w[gi][gj]),
                .l_data (cfg_data),
                .lon_in (lon_in_w[gi][gj]),
                .tr_in  (tr_in_w[gi][gj]),
                .lon_q  (lon_q[gi][gj]),
                .tr_q   (tr_q[gi][gj]),
                .acc_q  (acc_q[gi][gj])
            );
        end
    end

    assign v_out = sat_out(acc_q[rd_row][rd_col]);

    AST_DRAINED_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> (lon_in_w[DIM-1][DIM-1].tag == TAG_IDLE)); // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> $stable(v_out) || (rd_row != $past(rd_row)) || (rd_col != $past(rd_col))); // R9

endmodule

// File: tb/tb_lur_cyl_array.sv
module tb_lur_cyl_array;
    import lur_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 cfg_we;
    logic                 cfg_sel;
    logic [IW-1:0]        cfg_row;
    logic [IW-1:0]        cfg_col;
    logic signed [DW-1:0] cfg_data;
    logic                 u_valid;
    logic [DIM*DW-1:0]    u_col;
    logic                 start;
    logic                 done;
    logic [IW-1:0]        rd_row;
    logic [IW-1:0]        rd_col;
    logic signed [DW-1:0] v_out;

    int total = 0;
    int bad   = 0;
    int done_seen = 0;

    longint Lm [DIM][DIM];
    longint Rm [DIM][DIM];
    longint Um [DIM][DIM];
    longint exp_v [DIM][DIM];

    // behavioural model of the done pulse
    bit m_busy = 0;
    int m_cnt  = 0;
    bit exp_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lur_cyl_array dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_row(cfg_row),
        .cfg_col(cfg_col), .cfg_data(cfg_data), .u_valid(u_valid), .u_col(u_col),
        .start(start), .done(done), .rd_row(rd_row), .rd_col(rd_col), .v_out(v_out)
    );

    function automatic longint satb(longint x, int b);
        longint hi = (longint'(1) <<< (b - 1)) - 1;
        longint lo = -hi - 1;
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    // Reference: L*U clamped to 20 bits, accumulation clamped to 36 bits, output to 16
    function automatic longint ref_v(int i, int j);
        longint lu, acc;
        acc = 0;
        for (int k = 0; k < DIM; k++) begin
            lu = 0;
            for (int m = 0; m < DIM; m++) lu += Lm[i][m] * Um[m][k];
            lu  = satb(lu, FB_W);
            acc = satb(acc + lu * Rm[k][j], ACC_W);
        end
        return satb(acc, DW);
    endfunction

    // Kronecker form: entry j*DIM+i of (R^T kron L) applied to the vector u
    function automatic longint kron_v(int i, int j);
        longint s = 0;
        for (int k = 0; k < DIM; k++)
            for (int m = 0; m < DIM; m++)
                s += Rm[k][j] * Lm[i][m] * Um[m][k];
        return satb(s, DW);
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy   = 0;
            m_cnt    = 0;
            exp_done = 0;
        end else begin
            exp_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 4 * DIM - 2) begin
                    m_busy   = 0;
                    exp_done = 1;
                end
            end else if (start) begin
                m_busy = 1;
                m_cnt  = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R6", longint'(done), longint'(exp_done), "done per cycle");
            if (done) done_seen++;
        end
    end

    task automatic wr(bit sel, int r, int c, longint d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_row = IW'(r); cfg_col = IW'(c); cfg_data = DW'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic load_all();
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                wr(1'b0, r, c, Lm[r][c]);
                wr(1'b1, r, c, Rm[r][c]);
            end
        for (int c = 0; c < DIM; c++) begin
            @(negedge clk);
            u_valid = 1;
            for (int r = 0; r < DIM; r++) u_col[r*DW +: DW] = DW'(Um[r][c]);
            @(negedge clk);
            u_valid = 0;
        end
    endtask

    task automatic run_wait(bit extra_start);
        bit seen = 0;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        if (extra_start) begin
            @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        for (int n = 0; n < 40 && !seen; n++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) exp_v[i][j] = ref_v(i, j);
    endtask

    task automatic read_all(string req, bit with_kron);
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                rd_row = IW'(i); rd_col = IW'(j);
                #1;
                check(req, longint'(v_out), exp_v[i][j], $sformatf("V[%0d][%0d]", i, j));
                if (with_kron)
                    check("R3", longint'(v_out), kron_v(i, j), $sformatf("kron V[%0d][%0d]", i, j));
            end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_row = '0; cfg_col = '0; cfg_data = '0;
        u_valid = 0; u_col = '0; start = 0; rd_row = '0; rd_col = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1", longint'(done), 0, "done after reset");
        for (int i = 0; i < DIM; i++) for (int j = 0; j < DIM; j++) exp_v[i][j] = 0;
        read_all("R1", 1'b0);

        // R2, R3: fixed asymmetric operands exercise index mapping
        Lm = '{'{1, 2}, '{3, 4}};
        Um = '{'{5, 6}, '{7, -8}};
        Rm = '{'{1, 0}, '{2, -1}};
        load_all();
        run_wait(1'b0);
        read_all("R2", 1'b1);

        // R3, R8: several random small-range runs back to back
        for (int n = 0; n < 5; n++) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++) begin
                    Lm[r][c] = longint'($urandom_range(30)) - 15;
                    Rm[r][c] = longint'($urandom_range(30)) - 15;
                    Um[r][c] = longint'($urandom_range(60)) - 30;
                end
            load_all();
            run_wait(1'b0);
            read_all("R3", 1'b1);
        end

        // R8: same data again gives the same V, not a doubled one
        run_wait(1'b0);
        read_all("R8", 1'b0);

        // R4: L*U of 600000 clamps to 524287, minus 524000 leaves 287
        Lm = '{'{100, 100}, '{100, 100}};
        Um = '{'{3000, 2620}, '{3000, 2620}};
        Rm = '{'{1, 0}, '{-1, 1}};
        load_all();
        run_wait(1'b0);
        check("R4", exp_v[0][0], 287, "reference clamp value");
        read_all("R4", 1'b0);

        // R5: accumulator clamps at the positive 36-bit limit
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                Lm[r][c] = -32768; Um[r][c] = 32767; Rm[r][c] = -32768;
            end
        load_all();
        run_wait(1'b0);
        read_all("R5", 1'b0);

        // R5: negative output clamp
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) Rm[r][c] = 32767;
        load_all();
        run_wait(1'b0);
        read_all("R5", 1'b0);

        // R7: a second start during the run is ignored
        Lm = '{'{-3, 7}, '{2, 5}};
        Um = '{'{9, -4}, '{1, 6}};
        Rm = '{'{4, -2}, '{3, 8}};
        load_all();
        done_seen = 0;
        run_wait(1'b1);
        repeat (10) @(negedge clk);
        check("R7", longint'(done_seen), 1, "done pulses for one run");
        read_all("R7", 1'b1);

        // R9: new writes without start leave V unchanged
        Lm = '{'{11, 12}, '{13, 14}};
        Um = '{'{-1, -2}, '{-3, -4}};
        Rm = '{'{5, 5}, '{5, 5}};
        load_all();
        repeat (5) @(negedge clk);
        read_all("R9", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule